// File: doc/BRIEF.md
# Bit-Serial Matrix-Walk Hash Datapath

This block computes a hash defined as a walk of 2x2 matrices over the binary field GF(2^N): a pair of field elements (a, b) is updated once per message bit. A zero bit maps (a, b) to (a·X + b, a). A one bit maps (a, b) to (a·X + b, a·X + a + b). Multiplication by X is reduced modulo an irreducible polynomial of degree N. The design targets minimal area. Each state word is kept in an N-bit shift register with no parallel load. Only one bit position of a and b is computed per clock, so one message bit occupies N cycles.

Before a message, the key's initial vector is shifted in serially. Message bits then arrive one at a time under a valid/ready handshake, and an end strobe closes the message. Two more shift registers keep masked copies of a and b, XORed with a fixed 2N-bit constant. After the message, these copies feed 2N continuation bits back into the walk, one per pass. The resulting (a, b) is then shifted out serially, a first, then b, least significant bit first. After the output the block waits for a new initial vector.

Top module: `matwalk_serial_hash`

## Requirements
- R1: After reset, and after each digest, load_ready is high. Exactly 2N bits are accepted on iv_bit in the cycles where iv_valid is high. Accepted bit t becomes bit t of a for t < N, and bit t−N of b otherwise. After the last of these bits, load_ready falls and msg_ready rises.
- R2: A message bit is taken on a rising edge where msg_valid and msg_ready are both high. busy is then high for exactly N cycles. msg_ready is high in the last of those N cycles and while idle between bits, so a continuous stream costs N cycles per bit.
- R3: Each message bit m updates the state. With aX = a·X mod P, where P = X^N + sum of POLY[i]·X^i, the new state is (aX ^ b, a) for m = 0 and (aX ^ b, aX ^ a ^ b) for m = 1.
- R4: If msg_valid and msg_end are both high at an accepting edge, the message bit is taken and msg_end is not acted on.
- R5: msg_end, taken at an accepting edge with msg_valid low, starts a final phase of 2N further passes. Continuation bit t is a[t] ^ K[N+t] for t < N, and b[t−N] ^ K[t−N] for t ≥ N. Here (a, b) is the state at the end of the message, and mask bit K[i] equals MASK_SEED[i mod 64].
- R6: When bits and the end strobe are offered back to back, out_valid first rises exactly (k + 2N)·N cycles after the edge that takes the first bit of a k-bit message. For k = 0 the count starts at the edge that takes the end strobe.
- R7: The digest is presented on out_bit while out_valid is high, for exactly 2N consecutive cycles. Bits a[0..N−1] come first, then b[0..N−1]. load_ready is high in the cycle after the last digest bit.
- R8: iv_valid is ignored outside the load phase. msg_valid and msg_end are ignored while msg_ready is low, including during digest output.
- R9: A message of zero bits is valid; its digest is the final phase applied directly to the initial vector.
- R10: While reset is asserted and right after it, load_ready is 1 and msg_ready, busy and out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iv_valid | input | 1 | Initial-vector bit strobe |
| iv_bit | input | 1 | Initial-vector serial bit |
| msg_valid | input | 1 | Message bit strobe |
| msg_bit | input | 1 | Message serial bit |
| msg_end | input | 1 | End-of-message strobe |
| load_ready | output | 1 | Waiting for initial-vector bits |
| msg_ready | output | 1 | Pass boundary: a bit or end strobe is taken now |
| busy | output | 1 | A message or final-phase pass is running |
| out_valid | output | 1 | Digest bit valid |
| out_bit | output | 1 | Serial digest bit |

## Verification
The bench builds the block with N = 7, the polynomial X^7 + X + 1 and a fixed mask seed. A complete hash then takes only a few hundred cycles. Many randomly keyed messages of 0 to 12 bits, each with its 14-bit final phase, can therefore be compared against a bench model of the field arithmetic. The small N brings every pass boundary within reach: simultaneous bit and end strobes, strobes injected mid-pass and during output, initial-vector gaps, and exact latency counts. The default N = 127 parameter set is only elaborated.

// File: rtl/matwalk_serial_hash.sv
module matwalk_serial_hash #(
  parameter int          N         = 127,
  parameter logic [N-1:0] POLY     = {{(N-2){1'b0}}, 2'b11},
  parameter logic [63:0] MASK_SEED = 64'h243F6A8885A308D3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic iv_valid,
  input  logic iv_bit,
  input  logic msg_valid,
  input  logic msg_bit,
  input  logic msg_end,
  output logic load_ready,
  output logic msg_ready,
  output logic busy,
  output logic out_valid,
  output logic out_bit
);

  localparam int JW = (N > 2) ? $clog2(N) : 1;
  localparam int CW = $clog2(2 * N);

  function automatic logic [2*N-1:0] expand_mask(input logic [63:0] seed);
    logic [2*N-1:0] r;
    for (int i = 0; i < 2 * N; i++) r[i] = seed[i % 64];
    return r;
  endfunction

  localparam logic [2*N-1:0] MASK   = expand_mask(MASK_SEED);
  localparam logic [N-1:0]   MASK_A = MASK[2*N-1:N];
  localparam logic [N-1:0]   MASK_B = MASK[N-1:0];
  localparam logic [2*N-1:0] MASK_L = {MASK_B, MASK_A};

  typedef enum logic [2:0] {ST_LOAD, ST_IDLE, ST_MSG, ST_FIN, ST_OUT} st_t;

  st_t             st_q;
  logic [N-1:0]    a_q, b_q, am_q, bm_q;
  logic [JW-1:0]   j_q;
  logic [CW-1:0]   cnt_q;
  logic            mb_q, red_q, prev_q;

  logic j_last, cnt_last, m_cur, ax_j, na, nb, take_bit, take_end, red_nxt;

  assign j_last   = (j_q == JW'(N - 1));
  assign cnt_last = (cnt_q == CW'(2 * N - 1));
  assign m_cur    = (st_q == ST_FIN) ? am_q[0] : mb_q;
  assign ax_j     = prev_q ^ (red_q & POLY[j_q]);
  assign na       = ax_j ^ b_q[0];
  assign nb       = m_cur ? (ax_j ^ a_q[0] ^ b_q[0]) : a_q[0];
  assign red_nxt  = (st_q == ST_IDLE) ? a_q[N-1] : na;

  assign load_ready = (st_q == ST_LOAD);
  assign msg_ready  = (st_q == ST_IDLE) || (st_q == ST_MSG && j_last);
  assign busy       = (st_q == ST_MSG) || (st_q == ST_FIN);
  assign out_valid  = (st_q == ST_OUT);
  assign out_bit    = a_q[0];
  assign take_bit   = msg_ready && msg_valid;
  assign take_end   = msg_ready && !msg_valid && msg_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      a_q    <= '0;
      b_q    <= '0;
      am_q   <= '0;
      bm_q   <= '0;
      j_q    <= '0;
      cnt_q  <= '0;
      mb_q   <= 1'b0;
      red_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      case (st_q)
        ST_LOAD: if (iv_valid) begin
          a_q  <= {b_q[0], a_q[N-1:1]};
          b_q  <= {iv_bit, b_q[N-1:1]};
          am_q <= {bm_q[0], am_q[N-1:1]};
          bm_q <= {iv_bit ^ MASK_L[cnt_q], bm_q[N-1:1]};
          if (cnt_last) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_MSG: begin
          a_q    <= {na, a_q[N-1:1]};
          b_q    <= {nb, b_q[N-1:1]};
          am_q   <= {na ^ MASK_A[j_q], am_q[N-1:1]};
          bm_q   <= {nb ^ MASK_B[j_q], bm_q[N-1:1]};
          prev_q <= a_q[0];
          j_q    <= j_q + JW'(1);
          if (j_last) st_q <= ST_IDLE;
        end
        ST_FIN: begin
          a_q    <= {na, a_q[N-1:1]};
          b_q    <= {nb, b_q[N-1:1]};
          prev_q <= a_q[0];
          j_q    <= j_q + JW'(1);
          if (j_last) begin
            am_q   <= {bm_q[0], am_q[N-1:1]};
            bm_q   <= {1'b0, bm_q[N-1:1]};
            j_q    <= '0;
            prev_q <= 1'b0;
            red_q  <= na;
            if (cnt_last) begin
              cnt_q <= '0;
              st_q  <= ST_OUT;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        ST_OUT: begin
          a_q <= {b_q[0], a_q[N-1:1]};
          b_q <= {1'b0, b_q[N-1:1]};
          if (cnt_last) begin
            cnt_q <= '0;
            st_q  <= ST_LOAD;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: ;
      endcase
      if (take_bit || take_end) begin
        j_q    <= '0;
        prev_q <= 1'b0;
        red_q  <= red_nxt;
        mb_q   <= msg_bit;
        st_q   <= take_bit ? ST_MSG : ST_FIN;
        if (take_end) cnt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/matwalk_serial_hash_chk.sv
module matwalk_serial_hash_chk #(
  parameter int N = 127
) (
  input logic clk,
  input logic rst_n,
  input logic iv_valid,
  input logic msg_valid,
  input logic msg_end,
  input logic load_ready,
  input logic msg_ready,
  input logic busy,
  input logic out_valid
);

  localparam int RW = $clog2(2 * N + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= out_valid ? run_q + RW'(1) : '0;
  end

  a_r10_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ready, busy, out_valid, msg_ready && !busy}));

  a_r2_bit_starts_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> busy);

  a_r5_end_starts_final: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end && msg_ready) |=> busy);

  a_r1_load_exit: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |=> (load_ready || msg_ready));

  a_r8_iv_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && iv_valid) |=> !load_ready);

  a_r7_out_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run_q == RW'(2 * N)));

  a_r7_out_to_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> load_ready);

endmodule

bind matwalk_serial_hash matwalk_serial_hash_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .iv_valid(iv_valid), .msg_valid(msg_valid),
  .msg_end(msg_end), .load_ready(load_ready), .msg_ready(msg_ready),
  .busy(busy), .out_valid(out_valid)
);

// File: tb/matwalk_serial_hash_tb_top.sv
`timescale 1ns/100ps
module matwalk_serial_hash_tb_top;

  localparam int          N    = 7;
  localparam logic [N-1:0] POLY = 7'b0000011;
  localparam logic [63:0] SEED = 64'hC90FDAA22168C234;
  localparam int          MAXK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv_valid = 1'b0, iv_bit = 1'b0;
  logic msg_valid = 1'b0, msg_bit = 1'b0, msg_end = 1'b0;
  logic load_ready, msg_ready, busy, out_valid, out_bit;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  matwalk_serial_hash #(.N(N), .POLY(POLY), .MASK_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .iv_valid(iv_valid), .iv_bit(iv_bit),
    .msg_valid(msg_valid), .msg_bit(msg_bit), .msg_end(msg_end),
    .load_ready(load_ready), .msg_ready(msg_ready), .busy(busy),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] mulx(input logic [N-1:0] v);
    return {v[N-2:0], 1'b0} ^ (v[N-1] ? POLY : '0);
  endfunction

  function automatic logic [2*N-1:0] step(input logic [2*N-1:0] st, input logic m);
    logic [N-1:0] a, b, ax;
    a  = st[N-1:0];
    b  = st[2*N-1:N];
    ax = mulx(a);
    return {(m ? (ax ^ a ^ b) : a), ax ^ b};
  endfunction

  function automatic logic mask_bit(input int i);
    return SEED[i % 64];
  endfunction

  function automatic logic [2*N-1:0] ref_hash(input logic [2*N-1:0] iv, input int k,
                                              input logic [MAXK-1:0] bits);
    logic [2*N-1:0] st, mid;
    logic m;
    st = iv;
    for (int i = 0; i < k; i++) st = step(st, bits[i]);
    mid = st;
    for (int t = 0; t < 2 * N; t++) begin
      m  = (t < N) ? (mid[t] ^ mask_bit(N + t)) : (mid[t] ^ mask_bit(t - N));
      st = step(st, m);
    end
    return st;
  endfunction

  task automatic run_hash(input logic [2*N-1:0] iv, input int k, input logic [MAXK-1:0] bits,
                          input bit noise, input bit gaps, input bit both, input string tag);
    logic [2*N-1:0] exp, got;
    int c0, c1, nout;
    exp = ref_hash(iv, k, bits);
    c0  = 0;
    for (int t = 0; t < 2 * N; t++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        iv_valid = 1'b0;
        @(negedge clk);
      end
      iv_valid = 1'b1;
      iv_bit   = iv[t];
      @(negedge clk);
    end
    iv_valid = 1'b0;
    check(!load_ready && msg_ready, "R1", {tag, " load exit"}, {load_ready, msg_ready}, 2'b01);
    for (int i = 0; i < k; i++) begin
      msg_valid = 1'b1;
      msg_bit   = bits[i];
      msg_end   = both && (i == 0);
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
      msg_valid = 1'b0;
      msg_end   = 1'b0;
      if (i == 0) c0 = cyc;
      if (noise) begin
        msg_valid = 1'b1;
        msg_end   = 1'b1;
        iv_valid  = 1'b1;
        msg_bit   = ~msg_bit;
        @(negedge clk);
        msg_valid = 1'b0;
        msg_end   = 1'b0;
        iv_valid  = 1'b0;
      end
    end
    msg_end = 1'b1;
    while (!msg_ready) @(negedge clk);
    @(negedge clk);
    msg_end = 1'b0;
    if (k == 0) c0 = cyc;
    while (!out_valid) @(negedge clk);
    c1 = cyc;
    check((c1 - c0) == (k + 2 * N) * N, "R6", {tag, " latency"}, 64'(c1 - c0),
          64'((k + 2 * N) * N));
    nout = 0;
    for (int t = 0; t < 2 * N; t++) begin
      if (out_valid) nout++;
      got[t] = out_bit;
      if (noise && t < 2 * N - 1) begin
        iv_valid  = 1'b1;
        msg_valid = 1'b1;
        msg_end   = 1'b1;
      end else begin
        iv_valid  = 1'b0;
        msg_valid = 1'b0;
        msg_end   = 1'b0;
      end
      @(negedge clk);
    end
    iv_valid  = 1'b0;
    msg_valid = 1'b0;
    msg_end   = 1'b0;
    check(nout == 2 * N && !out_valid && load_ready, "R7", {tag, " output window"},
          64'({nout, out_valid, load_ready}), 64'({2 * N, 1'b0, 1'b1}));
    check(got == exp, "R5", {tag, " digest"}, 64'(got), 64'(exp));
  endtask

  initial begin
    int seed_dummy;
    logic [2*N-1:0] iv;
    seed_dummy = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    check(load_ready && !msg_ready && !busy && !out_valid, "R10", "in reset",
          {load_ready, msg_ready, busy, out_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(load_ready && !msg_ready && !busy && !out_valid, "R10", "after reset",
          {load_ready, msg_ready, busy, out_valid}, 4'b1000);

    run_hash(14'h0001, 0, '0, 1'b0, 1'b0, 1'b0, "R9 empty message");
    run_hash(14'h2A55, 1, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 single zero bit");
    run_hash(14'h2A55, 1, 16'h0001, 1'b0, 1'b0, 1'b0, "R3 single one bit");
    run_hash(14'h3FFF, 12, 16'h0FFF, 1'b1, 1'b0, 1'b0, "R8 ones with strobe noise");
    run_hash(14'h1234, 5, 16'h0016, 1'b0, 1'b1, 1'b1, "R4 bit and end together");
    run_hash(14'h0080, 8, 16'h00A5, 1'b0, 1'b1, 1'b0, "R2 stream with iv gaps");

    for (int r = 0; r < 24; r++) begin
      int k;
      logic both;
      do iv = (2*N)'($urandom); while (iv == '0);
      k    = $urandom_range(0, 12);
      both = (k > 0) && ($urandom % 4 == 0);
      run_hash(iv, k, MAXK'($urandom), 1'($urandom), 1'($urandom), both, "R3 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule